// File: doc/BRIEF.md
# Byte-Lane Fast-Page DRAM Controller with Timed Refresh

This controller sits between a 16-bit processor bus and a 32-bit-wide bank of fast-page-mode DRAM that is split into 1 MB segments. Each processor request reaches one 16-bit half of a 32-bit memory word. Address bit 1 picks the half, and the upper and lower byte strobes pick the bytes within it. Together they drive four active-low column strobes, one for each byte lane. The upper address bits pick one active-low row strobe, one line per segment. Row and column addresses share one multiplexed DRAM address bus. Write data is copied onto both halves of the 32-bit DRAM data bus, and read data is taken from the half named by address bit 1.

A free-running divider raises a refresh request at a fixed interval and holds at most one request. The refresh is a CAS-before-RAS cycle that strikes every segment together. It uses the DRAM's internal row counter, so it keeps no record of which rows were used recently. A refresh has priority over a new processor request. After an access the row stays open, so a following request to the same segment and row needs only a new column strobe.

The state machine has seven states. IDLE: nothing is driven. ROW: the row strobe and the row address are out. COL: the column strobes, the column address and the acknowledge are out. PAGE: the row is held open and the column strobes are high. PRE: one cycle of RAS precharge. RCAS: all column strobes go low. RRAS: all row strobes go low as well. The transitions are:
- IDLE goes to RCAS when a refresh is pending. Otherwise it goes to ROW when a request is present.
- ROW always goes to COL, and COL always goes to PAGE.
- PAGE goes to PRE on a pending refresh or on a request to a different segment or row. It goes to COL on a request to the open row. With no request it stays in PAGE.
- PRE goes to RCAS on a pending refresh. Otherwise it goes to ROW on a request, and to IDLE when there is none.
- RCAS always goes to RRAS, and RRAS always goes to PRE.

Top module: `dram_lane_ctrl`

## Requirements
- R1: During reset and right after it, every row strobe and column strobe is high, the write strobe is high and the acknowledge is low.
- R2: In the acknowledge cycle, column strobe k is low exactly when the segment is valid and A1 equals bit 1 of k and the matching byte strobe is set. Bit 0 of k set means the upper strobe (data bits 15:8), clear means the lower strobe. So lane 0 is A1=0 with lower, lane 1 is A1=0 with upper, lane 2 is A1=1 with lower, and lane 3 is A1=1 with upper. A request with neither strobe set is still acknowledged, with no lane low.
- R3: Address bits 23:20 give the segment number. For segment s below 12, only row strobe s goes low during the access. For segments 12 to 15, no row strobe and no column strobe goes low, but the request is still acknowledged.
- R4: An access that opens a row spends one cycle with the row strobe low, the column strobes high and address bits 19:11 on the DRAM address. In the next cycle the acknowledge is high, the column strobes are low and address bits 10:2 are on the DRAM address. A request presented in IDLE is acknowledged on the second cycle.
- R5: A request to the open segment and row is served from PAGE without a precharge. If it is presented in the cycle right after the previous acknowledge, its acknowledge comes 2 cycles later; if it is presented later, 1 cycle later. A request to another row needs 4 cycles or 3 cycles in the same two cases.
- R6: The set of low row strobes never changes from one non-empty set to another without at least one cycle in which all row strobes are high.
- R7: The write strobe is low in the acknowledge cycle of a write (read/write input low) and high for a read.
- R8: The processor's write data appears on DRAM data bits 15:0 and 31:16. The read data is DRAM bits 31:16 when A1 is 1 and bits 15:0 when A1 is 0. Data written through any lane pattern reads back unchanged.
- R9: A refresh drives all four column strobes low for one cycle with all row strobes high. In the next cycle all row strobes are also low. During that cycle the write strobe is high and there is no acknowledge.
- R10: A refresh begins no later than 788 cycles after the previous one, or after reset. This is an interval of 780 cycles (15.6 us at 50 MHz) plus an 8-cycle delay allowance. Only one refresh request is held at a time.
- R11: A request that arrives while a refresh is starting is held off until the precharge after the refresh. When it is presented in the RCAS cycle, its acknowledge comes 4 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request valid; held until acknowledged |
| cpu_addr | input | 23 | Byte-pair address, bits 23:1 |
| cpu_uds | input | 1 | Upper byte strobe (data 15:8) |
| cpu_lds | input | 1 | Lower byte strobe (data 7:0) |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid with the acknowledge |
| cpu_ack | output | 1 | One-cycle acknowledge |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 12 | Row strobes, one per 1 MB segment |
| dram_cas_n | output | 4 | Column strobes, one per byte lane |
| dram_we_n | output | 1 | Write strobe |
| dram_wdata | output | 32 | Write data, copied onto both halves |
| dram_rdata | input | 32 | Read data from the array |

## Verification
Every result is due a fixed number of cycles after its request:
- 2 cycles from IDLE.
- 2 or 1 cycles for an open-row hit, depending on whether the request comes right after the previous acknowledge.
- 4 or 3 cycles for a row miss, on the same rule.
- 4 cycles when the request arrives in the RCAS cycle.

The bench works out the expected cycle count from its own record of the open row and of the idle gap. It counts clock cycles until the acknowledge and compares that count with the expected one. Lanes, row strobes, the write strobe, the column address and the read data are checked in the acknowledge cycle. The row address is checked one cycle earlier. The latency is not compared when a refresh began during the wait or just before it. Refresh ordering, precharge and the refresh interval are checked in every cycle by a monitor that also acts as a behavioural DRAM, storing bytes by segment, latched row and column.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ROW  = 3'd1,
        ST_COL  = 3'd2,
        ST_PAGE = 3'd3,
        ST_PRE  = 3'd4,
        ST_RCAS = 3'd5,
        ST_RRAS = 3'd6
    } dlc_state_e;

    localparam int unsigned LANES   = 4;
    localparam int unsigned LANE_W  = 8;
    localparam int unsigned HALF_W  = 16;
    localparam int unsigned WORD_W  = 32;

endpackage

// File: rtl/dlc_refresh_timer.sv
module dlc_refresh_timer #(
    parameter int unsigned REF_DIV = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_taken,
    output logic ref_pending
);
    localparam int unsigned CNT_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            ref_pending <= 1'b0;
        end else begin
            cnt_q       <= tick ? '0 : cnt_q + 1'b1;
            ref_pending <= tick | (ref_pending & ~ref_taken);
        end
    end

    // R10: a queued refresh is only dropped when the controller takes it
    p_pending_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pending && !ref_taken) |=> ref_pending);

endmodule

// File: rtl/dlc_seg_decode.sv
module dlc_seg_decode #(
    parameter int unsigned SEG_W   = 4,
    parameter int unsigned NUM_SEG = 12
) (
    input  logic [SEG_W-1:0]   seg,
    output logic [NUM_SEG-1:0] seg_ras_n,
    output logic               seg_ok
);
    localparam logic [SEG_W:0] SEG_LIMIT = (SEG_W+1)'(NUM_SEG);

    assign seg_ok = ({1'b0, seg} < SEG_LIMIT);

    for (genvar k = 0; k < NUM_SEG; k++) begin : g_ras
        assign seg_ras_n[k] = ~(seg == SEG_W'(k));
    end

endmodule

// File: rtl/dlc_lane_steer.sv
module dlc_lane_steer
    import dlc_pkg::*;
(
    input  logic              en,
    input  logic              a1,
    input  logic              uds,
    input  logic              lds,
    input  logic [HALF_W-1:0] cpu_wdata,
    input  logic [WORD_W-1:0] dram_rdata,
    output logic [LANES-1:0]  lane_cas_n,
    output logic [WORD_W-1:0] dram_wdata,
    output logic [HALF_W-1:0] cpu_rdata
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic HALF  = (k / 2) == 1;
        localparam logic UPPER = (k % 2) == 1;
        logic strobe;
        assign strobe        = UPPER ? uds : lds;
        assign lane_cas_n[k] = ~(en && (a1 == HALF) && strobe);
        assign dram_wdata[k*LANE_W +: LANE_W] =
            cpu_wdata[(k % 2)*LANE_W +: LANE_W];
    end

    assign cpu_rdata = a1 ? dram_rdata[WORD_W-1:HALF_W] : dram_rdata[HALF_W-1:0];

endmodule

// File: rtl/dram_lane_ctrl.sv
module dram_lane_ctrl
    import dlc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 24,
    parameter int unsigned SEG_SHIFT = 20,
    parameter int unsigned NUM_SEG   = 12,
    parameter int unsigned COL_W     = 9,
    parameter int unsigned REF_DIV   = 780,
    localparam int unsigned SEG_W    = ADDR_W - SEG_SHIFT,
    localparam int unsigned ROW_W    = SEG_SHIFT - 2 - COL_W,
    localparam int unsigned MA_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic [ADDR_W-1:1]   cpu_addr,
    input  logic                cpu_uds,
    input  logic                cpu_lds,
    input  logic                cpu_rw,
    input  logic [15:0]         cpu_wdata,
    output logic [15:0]         cpu_rdata,
    output logic                cpu_ack,
    output logic [MA_W-1:0]     dram_addr,
    output logic [NUM_SEG-1:0]  dram_ras_n,
    output logic [3:0]          dram_cas_n,
    output logic                dram_we_n,
    output logic [31:0]         dram_wdata,
    input  logic [31:0]         dram_rdata
);
    localparam int unsigned COL_LO = 2;
    localparam int unsigned ROW_LO = COL_LO + COL_W;

    dlc_state_e state_q, state_d;

    logic [ADDR_W-1:1] lat_addr_q;
    logic              lat_uds_q, lat_lds_q, lat_rw_q;

    logic [SEG_W-1:0]  lat_seg, req_seg;
    logic [ROW_W-1:0]  lat_row, req_row;
    logic [COL_W-1:0]  lat_col;
    logic              row_hit, load_req;
    logic              ref_pending, ref_taken;
    logic [NUM_SEG-1:0] seg_ras_n;
    logic              seg_ok;
    logic [3:0]        lane_cas_n;

    assign lat_seg = lat_addr_q[ADDR_W-1:SEG_SHIFT];
    assign lat_row = lat_addr_q[SEG_SHIFT-1:ROW_LO];
    assign lat_col = lat_addr_q[ROW_LO-1:COL_LO];
    assign req_seg = cpu_addr[ADDR_W-1:SEG_SHIFT];
    assign req_row = cpu_addr[SEG_SHIFT-1:ROW_LO];
    assign row_hit = (req_seg == lat_seg) && (req_row == lat_row);

    assign ref_taken = (state_q == ST_RCAS);

    dlc_refresh_timer #(
        .REF_DIV (REF_DIV)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_taken   (ref_taken),
        .ref_pending (ref_pending)
    );

    dlc_seg_decode #(
        .SEG_W   (SEG_W),
        .NUM_SEG (NUM_SEG)
    ) u_seg (
        .seg       (lat_seg),
        .seg_ras_n (seg_ras_n),
        .seg_ok    (seg_ok)
    );

    dlc_lane_steer u_lane (
        .en         (seg_ok),
        .a1         (lat_addr_q[1]),
        .uds        (lat_uds_q),
        .lds        (lat_lds_q),
        .cpu_wdata  (cpu_wdata),
        .dram_rdata (dram_rdata),
        .lane_cas_n (lane_cas_n),
        .dram_wdata (dram_wdata),
        .cpu_rdata  (cpu_rdata)
    );

    // next-state selection
    always_comb begin
        state_d  = state_q;
        load_req = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_pending) begin
                    state_d = ST_RCAS;
                end else if (cpu_req) begin
                    state_d  = ST_ROW;
                    load_req = 1'b1;
                end
            end
            ST_ROW:  state_d = ST_COL;
            ST_COL:  state_d = ST_PAGE;
            ST_PAGE: begin
                if (ref_pending) begin
                    state_d = ST_PRE;
                end else if (cpu_req && row_hit) begin
                    state_d  = ST_COL;
                    load_req = 1'b1;
                end else if (cpu_req) begin
                    state_d = ST_PRE;
                end
            end
            ST_PRE: begin
                if (ref_pending) begin
                    state_d = ST_RCAS;
                end else if (cpu_req) begin
                    state_d  = ST_ROW;
                    load_req = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_RCAS: state_d = ST_RRAS;
            ST_RRAS: state_d = ST_PRE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state and request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            lat_addr_q <= '0;
            lat_uds_q  <= 1'b0;
            lat_lds_q  <= 1'b0;
            lat_rw_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            if (load_req) begin
                lat_addr_q <= cpu_addr;
                lat_uds_q  <= cpu_uds;
                lat_lds_q  <= cpu_lds;
                lat_rw_q   <= cpu_rw;
            end
        end
    end

    // outputs from registered state
    always_comb begin
        dram_ras_n = '1;
        dram_cas_n = '1;
        dram_we_n  = 1'b1;
        dram_addr  = MA_W'(lat_col);
        cpu_ack    = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_PRE: ;
            ST_ROW: begin
                dram_ras_n = seg_ras_n;
                dram_addr  = MA_W'(lat_row);
            end
            ST_COL: begin
                dram_ras_n = seg_ras_n;
                dram_cas_n = lane_cas_n;
                dram_we_n  = lat_rw_q | ~seg_ok;
                cpu_ack    = 1'b1;
            end
            ST_PAGE: dram_ras_n = seg_ras_n;
            ST_RCAS: dram_cas_n = '0;
            ST_RRAS: begin
                dram_cas_n = '0;
                dram_ras_n = '0;
            end
            default: ;
        endcase
    end

    // R2: one access never strobes both halves of the word
    p_half_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_ras_n != '0 && dram_ras_n != '1) |-> (&dram_cas_n[1:0] || &dram_cas_n[3:2]));

    // R3: at most one segment row strobe during an access
    p_one_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_ras_n != '0) |-> ($countones(~dram_ras_n) <= 1));

    // R6: the open segment changes only through an all-high cycle
    p_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_ras_n != '1 && $past(dram_ras_n) != '1) |-> (dram_ras_n == $past(dram_ras_n)));

    // R7: reads keep the write strobe high
    p_read_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && lat_rw_q) |-> dram_we_n);

    // R9: all row strobes low only after a cycle of all column strobes low
    p_cbr_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_ras_n == '0) |-> ($past(dram_cas_n) == '0 && $past(dram_ras_n) == '1 && dram_we_n));

    // R11: no acknowledge while the refresh holds the array
    p_no_ack_refresh_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_ras_n == '0 || (dram_cas_n == '0 && dram_ras_n == '1)) |-> !cpu_ack);

endmodule

// File: tb/dram_lane_ctrl_test.sv
module dram_lane_ctrl_test;
    localparam int NSEG  = 12;
    localparam int RDIV  = 780;
    localparam int LIM   = RDIV + 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [23:1] cpu_addr = '0;
    logic        cpu_uds = 1'b0, cpu_lds = 1'b0, cpu_rw = 1'b1;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ack;
    logic [8:0]  dram_addr;
    logic [NSEG-1:0] dram_ras_n;
    logic [3:0]  dram_cas_n;
    logic        dram_we_n;
    logic [31:0] dram_wdata;
    logic [31:0] dram_rdata = '0;

    always #10 clk = ~clk;

    dram_lane_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_uds(cpu_uds), .cpu_lds(cpu_lds), .cpu_rw(cpu_rw),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // behavioural DRAM and per-cycle monitor
    logic [8:0]  row_lat [NSEG];
    logic [31:0] dmem [int unsigned];
    logic [NSEG-1:0] prv_ras;
    logic [3:0]  prv_cas;
    int  since_ref = 0;
    int  ref_count = 0;
    bit  open_valid = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prv_ras   = '1;
            prv_cas   = '1;
            since_ref = 0;
        end else begin
            since_ref++;
            if (dram_cas_n == 4'h0 && dram_ras_n == '1 && prv_cas != 4'h0) begin
                check(since_ref <= LIM, "R10", "refresh interval", since_ref, LIM);
                ref_count++;
                since_ref  = 0;
                open_valid = 1'b0;
            end
            if (dram_ras_n == '0)
                check(prv_cas == 4'h0 && prv_ras == '1 && dram_we_n && !cpu_ack,
                      "R9", "CBR order", {prv_cas, 3'b0, dram_we_n, 3'b0, cpu_ack}, 32'h0010);
            if (dram_ras_n != prv_ras)
                check(!(prv_ras != '1 && dram_ras_n != '1), "R6", "precharge",
                      32'(dram_ras_n), 32'hFFF);
            for (int k = 0; k < NSEG; k++)
                if (prv_ras[k] && !dram_ras_n[k] && dram_cas_n == 4'hF)
                    row_lat[k] = dram_addr;
            if (prv_cas == 4'hF && dram_cas_n != 4'hF && dram_ras_n != '1) begin
                int sk = 0;
                int unsigned key;
                logic [31:0] w;
                for (int k = 0; k < NSEG; k++) if (!dram_ras_n[k]) sk = k;
                key = (int'(sk) << 18) | (32'(row_lat[sk]) << 9) | 32'(dram_addr);
                w = dmem.exists(key) ? dmem[key] : 32'h0;
                if (!dram_we_n) begin
                    for (int b = 0; b < 4; b++)
                        if (!dram_cas_n[b]) w[b*8 +: 8] = dram_wdata[b*8 +: 8];
                    dmem[key] = w;
                end else begin
                    dram_rdata = w;
                end
            end
            prv_ras = dram_ras_n;
            prv_cas = dram_cas_n;
        end
    end

    // bench-side expectation state
    logic [7:0] ref_mem [int unsigned];
    logic [3:0] open_seg;
    logic [8:0] open_row;
    bit just_acked = 1'b0;

    function automatic logic [23:1] mk_addr(input int seg, input int row,
                                            input int col, input bit a1);
        return {4'(seg), 9'(row), 9'(col), a1};
    endfunction

    function automatic logic [3:0] exp_lanes(input bit ok, input bit a1,
                                             input bit u, input bit l);
        logic [3:0] c;
        for (int k = 0; k < 4; k++)
            c[k] = ~(ok && (a1 == k[1]) && (k[0] ? u : l));
        return c;
    endfunction

    function automatic logic [7:0] ref_byte(input logic [23:1] a, input bit lo);
        int unsigned key = {8'h0, a, lo};
        return ref_mem.exists(key) ? ref_mem[key] : 8'h00;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
        if (n > 0) just_acked = 1'b0;
    endtask

    task automatic do_access(input logic [23:1] a, input bit rw, input bit u,
                             input bit l, input logic [15:0] wd, input int lat_ovr);
        int seg = int'(a[23:20]);
        int row = int'(a[19:11]);
        bit ok  = seg < NSEG;
        bit hit = open_valid && open_seg == a[23:20] && open_row == a[19:11];
        bit opens = !hit;
        int exp_lat;
        int snap = ref_count;
        bit fresh_ok = since_ref >= 4 || !open_valid ? (since_ref >= 4) : 1'b1;
        int n = 0;
        logic [8:0] pv_addr = '0;
        logic [3:0] pv_cas = '1;
        logic [NSEG-1:0] pv_ras = '1;
        logic [NSEG-1:0] ras_exp;
        if (!open_valid)     exp_lat = 2;
        else if (hit)        exp_lat = just_acked ? 2 : 1;
        else                 exp_lat = just_acked ? 4 : 3;
        if (lat_ovr > 0) exp_lat = lat_ovr;
        ras_exp = ok ? ~(NSEG'(1) << seg) : '1;
        cpu_req = 1'b1; cpu_addr = a; cpu_rw = rw; cpu_uds = u; cpu_lds = l;
        cpu_wdata = wd;
        forever begin
            pv_addr = dram_addr; pv_cas = dram_cas_n; pv_ras = dram_ras_n;
            @(negedge clk); #1;
            n++;
            if (cpu_ack) break;
            if (n > 40) begin
                check(1'b0, "R4", "watchdog on acknowledge", n, 40);
                break;
            end
        end
        if (cpu_ack) begin
            check(dram_cas_n == exp_lanes(ok, a[1], u, l), "R2", "lane strobes",
                  32'(dram_cas_n), 32'(exp_lanes(ok, a[1], u, l)));
            check(dram_ras_n == ras_exp, "R3", "segment strobe",
                  32'(dram_ras_n), 32'(ras_exp));
            check(dram_we_n == (rw | !ok), "R7", "write strobe",
                  32'(dram_we_n), 32'(rw | !ok));
            check(dram_addr == a[10:2], "R4", "column address",
                  32'(dram_addr), 32'(a[10:2]));
            if (lat_ovr > 0)
                check(n == exp_lat, "R11", "latency after refresh", n, exp_lat);
            else if (ref_count == snap && fresh_ok)
                check(n == exp_lat, hit ? "R5" : "R4", "latency", n, exp_lat);
            if (opens && ok && ref_count == snap)
                check(pv_addr == a[19:11] && pv_cas == 4'hF && pv_ras == ras_exp,
                      "R4", "row phase", {pv_cas, 7'h0, pv_addr}, {4'hF, 7'h0, 9'(row)});
            if (!rw && !ok)
                check(1'b1, "R3", "out-of-range write acknowledged", 1, 1);
            if (rw && ok) begin
                logic [15:0] e = {ref_byte(a, 1'b0), ref_byte(a, 1'b1)};
                logic [15:0] m = {{8{u}}, {8{l}}};
                check((cpu_rdata & m) == (e & m), "R8", "read data",
                      32'(cpu_rdata & m), 32'(e & m));
            end
            if (!rw && ok) begin
                check(dram_wdata == {wd, wd}, "R8", "write steering",
                      dram_wdata, {wd, wd});
                if (u) ref_mem[{8'h0, a, 1'b0}] = wd[15:8];
                if (l) ref_mem[{8'h0, a, 1'b1}] = wd[7:0];
            end
        end
        open_valid = 1'b1;
        open_seg   = a[23:20];
        open_row   = a[19:11];
        just_acked = 1'b1;
        cpu_req    = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1;
        check(dram_ras_n == '1 && dram_cas_n == 4'hF && dram_we_n && !cpu_ack,
              "R1", "outputs in reset", {dram_cas_n, dram_we_n, cpu_ack}, 6'b111110);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(dram_ras_n == '1 && dram_cas_n == 4'hF && dram_we_n && !cpu_ack,
              "R1", "outputs after reset", {dram_cas_n, dram_we_n, cpu_ack}, 6'b111110);

        // R2 / R8: every A1 / upper / lower combination, write then read
        for (int c = 0; c < 8; c++) begin
            do_access(mk_addr(0, 5, 3, c[2]), 1'b0, c[1], c[0],
                      16'h1111 * 16'(c + 1), 0);
            idle(1);
        end
        for (int c = 0; c < 8; c++) begin
            do_access(mk_addr(0, 5, 3, c[2]), 1'b1, c[1], c[0], 16'h0, 0);
        end
        idle(2);

        // R3: each segment, including the unmapped ones
        for (int s = 0; s < 16; s++) begin
            do_access(mk_addr(s, 7, 1, 1'b0), 1'b0, 1'b1, 1'b1, 16'(16'hA500 + s), 0);
            do_access(mk_addr(s, 9, 1, 1'b0), 1'b1, 1'b1, 1'b1, 16'h0, 0);
            idle(1);
        end

        // R5: open-row hits back to back and after a gap, then a miss
        do_access(mk_addr(3, 20, 0, 1'b1), 1'b0, 1'b1, 1'b1, 16'hBEEF, 0);
        do_access(mk_addr(3, 20, 1, 1'b0), 1'b0, 1'b1, 1'b0, 16'hC300, 0);
        idle(2);
        do_access(mk_addr(3, 20, 0, 1'b1), 1'b1, 1'b1, 1'b1, 16'h0, 0);
        do_access(mk_addr(3, 21, 0, 1'b1), 1'b1, 1'b1, 1'b1, 16'h0, 0);

        // R11: request presented in the first refresh cycle
        for (int w = 0; w < 2000; w++) begin
            if (dram_cas_n == 4'h0 && dram_ras_n == '1) break;
            @(negedge clk); #1;
        end
        do_access(mk_addr(1, 2, 2, 1'b0), 1'b1, 1'b1, 1'b1, 16'h0, 4);

        // random mix
        for (int i = 0; i < 2500; i++) begin
            int rows[4] = '{0, 1, 2, 511};
            int seg = int'($urandom % 14);
            int r   = int'($urandom % 8);
            logic [23:1] a = mk_addr(seg, rows[$urandom % 4], int'($urandom % 16),
                                     1'($urandom));
            do_access(a, 1'($urandom), r != 1, r != 2, 16'($urandom), 0);
            if (($urandom % 3) == 0) idle(int'($urandom % 4) + 1);
        end

        // R10: long idle with the row left open
        idle(2 * RDIV);
        check(since_ref <= LIM, "R10", "interval while idle", since_ref, LIM);
        check(ref_count >= 5, "R10", "refresh count", ref_count, 5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule